// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block steps a horizontally microcoded control unit through its control store. It holds a 512-word store of 36-bit microwords and a microword register, and it forms the 9-bit microprogram address for each next fetch. The address comes from three inputs: the next-address field and the three branch-select bits of the microword just executed, the sign and zero flags the ALU produced for that microword, and the current opcode byte.

Branches do not use an adder or a target multiplexer. A two-way conditional branch ORs a selected flag into address bit 8, so the two successors of a microword are some address X and X+0x100. An opcode dispatch ORs the opcode byte into address bits 7..0. A dispatch whose next-address field is 0x100 therefore lands in the upper half of the store, which holds the wide-index variants of the instructions.

Each microword takes two clock cycles:
- **Fetch cycle:** the address is formed and the store is read into the microword register.
- **Execute cycle:** the microword is presented to the datapath. At the end of this cycle the ALU flags and the branch fields are captured in flip-flops, so they stay valid while the next address is formed.

`mir_valid` is high during execute cycles. There is no ready input: the datapath must take every microword in its execute cycle, and back-pressure is not possible. The store is filled through a plain write port, which may be used while reset is held.

Top module: `usq_sequencer`

## Requirements
- R1: While `rst_n` is low, `mpc_o` is 0 and `mir_valid` is 0. The first fetch after reset reads address 0, whatever the opcode and flag inputs are.
- R2: The microword layout is: bits 35..27 next-address field, bit 26 dispatch select, bit 25 sign-branch select, bit 24 zero-branch select, 23..16 ALU control, 15..7 register-write select, 6..4 memory operation, 3..0 B-source select. The four control fields appear on `alu_ctrl_o`, `c_wr_o`, `mem_op_o` and `b_src_o`.
- R3: In a fetch cycle, `mpc_o[8]` = next-address[8] OR (zero-select AND captured Z) OR (sign-select AND captured N).
- R4: In a fetch cycle, `mpc_o[7:0]` = `opcode_i` OR next-address[7:0] when dispatch select is set, and next-address[7:0] otherwise.
- R5: A microword with next-address 0x092 and only zero-select set is followed by 0x192 when Z was 1 and by 0x092 when Z was 0.
- R6: `alu_n` and `alu_z` are captured only at the end of an execute cycle. Their values during a fetch cycle have no effect on the address.
- R7: A dispatch microword with next-address 0x100 and opcode 0xC4 is followed by address 0x1C4.
- R8: `mir_valid` alternates every cycle after reset, starting low. `mir_o` holds the store word at the address shown on `mpc_o` in the preceding fetch cycle, and does not change between an execute cycle and the fetch cycle that follows it.
- R9: When dispatch select is clear, `opcode_i` has no effect on the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_we | input | 1 | Control store write strobe |
| cs_waddr | input | 9 | Control store write address |
| cs_wdata | input | 36 | Control store write word |
| opcode_i | input | 8 | Opcode byte, used in fetch cycles for dispatch |
| alu_n | input | 1 | ALU sign flag for the executing microword |
| alu_z | input | 1 | ALU zero flag for the executing microword |
| mpc_o | output | 9 | Microprogram address; meaningful in fetch cycles |
| mir_o | output | 36 | Microword register |
| mir_valid | output | 1 | High in execute cycles |
| alu_ctrl_o | output | 8 | ALU control field of `mir_o` |
| c_wr_o | output | 9 | Register-write select field of `mir_o` |
| mem_op_o | output | 3 | Memory operation field of `mir_o` |
| b_src_o | output | 4 | B-source select field of `mir_o` |

## Verification
A corrupted captured flag or held branch field shows up on `mpc_o` in the very next fetch cycle as an address off by 0x100 or by OR-ed opcode bits. One cycle later, `mir_o` carries the wrong word. A wrong phase bit breaks the strict alternation of `mir_valid` at once. A wrong store read gives a `mir_o` word that differs from the word written at the fetched address. The bench walks long chains of microwords that cover every branch-select combination under both flag values, so a single bad address makes every later step miscompare.

// File: rtl/usq_pkg.sv
package usq_pkg;
  parameter int unsigned UA_W  = 9;
  parameter int unsigned JAM_W = 3;
  parameter int unsigned ALU_W = 8;
  parameter int unsigned CW_W  = 9;
  parameter int unsigned MEM_W = 3;
  parameter int unsigned BS_W  = 4;
  parameter int unsigned OPC_W = UA_W - 1;

  localparam int unsigned WORD_W  = UA_W + JAM_W + ALU_W + CW_W + MEM_W + BS_W;
  localparam int unsigned BS_LSB  = 0;
  localparam int unsigned MEM_LSB = BS_LSB + BS_W;
  localparam int unsigned CW_LSB  = MEM_LSB + MEM_W;
  localparam int unsigned ALU_LSB = CW_LSB + CW_W;
  localparam int unsigned JAM_LSB = ALU_LSB + ALU_W;
  localparam int unsigned UA_LSB  = JAM_LSB + JAM_W;

  // positions inside the branch-select group
  localparam int unsigned SEL_Z  = 0;
  localparam int unsigned SEL_N  = 1;
  localparam int unsigned SEL_PC = 2;
endpackage

// File: rtl/usq_ctrl_store.sv
module usq_ctrl_store #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/usq_flag_hold.sv
module usq_flag_hold #(
  parameter int unsigned AW = 9,
  parameter int unsigned JW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          n_in,
  input  logic          z_in,
  input  logic [AW-1:0] ua_in,
  input  logic [JW-1:0] sel_in,
  output logic          n_q,
  output logic          z_q,
  output logic [AW-1:0] ua_q,
  output logic [JW-1:0] sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= 1'b0;
      z_q   <= 1'b0;
      ua_q  <= '0;
      sel_q <= '0;
    end else if (cap) begin
      n_q   <= n_in;
      z_q   <= z_in;
      ua_q  <= ua_in;
      sel_q <= sel_in;
    end
  end
endmodule

// File: rtl/usq_next_addr.sv
module usq_next_addr
  import usq_pkg::*;
#(
  parameter int unsigned AW = UA_W,
  parameter int unsigned OW = AW - 1,
  parameter int unsigned JW = JAM_W
) (
  input  logic [AW-1:0] ua,
  input  logic [JW-1:0] sel,
  input  logic          n,
  input  logic          z,
  input  logic [OW-1:0] opcode,
  output logic [AW-1:0] mpc
);
  logic hi_bit;

  assign hi_bit = ua[AW-1] | (sel[SEL_Z] & z) | (sel[SEL_N] & n);

  for (genvar i = 0; i < OW; i++) begin : g_low
    assign mpc[i] = ua[i] | (sel[SEL_PC] & opcode[i]);
  end

  assign mpc[AW-1] = hi_bit;
endmodule

// File: rtl/usq_sequencer.sv
module usq_sequencer
  import usq_pkg::*;
#(
  parameter int unsigned AW  = UA_W,
  parameter int unsigned OW  = OPC_W,
  parameter int unsigned DW  = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_we,
  input  logic [AW-1:0]    cs_waddr,
  input  logic [DW-1:0]    cs_wdata,
  input  logic [OW-1:0]    opcode_i,
  input  logic             alu_n,
  input  logic             alu_z,
  output logic [AW-1:0]    mpc_o,
  output logic [DW-1:0]    mir_o,
  output logic             mir_valid,
  output logic [ALU_W-1:0] alu_ctrl_o,
  output logic [CW_W-1:0]  c_wr_o,
  output logic [MEM_W-1:0] mem_op_o,
  output logic [BS_W-1:0]  b_src_o
);
  logic              exec_q;
  logic              n_h, z_h;
  logic [AW-1:0]     ua_h;
  logic [JAM_W-1:0]  sel_h;
  logic [AW-1:0]     mpc;
  logic [DW-1:0]     mir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exec_q <= 1'b0;
    else        exec_q <= ~exec_q;
  end

  usq_flag_hold #(.AW(AW), .JW(JAM_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap    (exec_q),
    .n_in   (alu_n),
    .z_in   (alu_z),
    .ua_in  (mir[UA_LSB +: AW]),
    .sel_in (mir[JAM_LSB +: JAM_W]),
    .n_q    (n_h),
    .z_q    (z_h),
    .ua_q   (ua_h),
    .sel_q  (sel_h)
  );

  usq_next_addr #(.AW(AW), .OW(OW), .JW(JAM_W)) u_next (
    .ua     (ua_h),
    .sel    (sel_h),
    .n      (n_h),
    .z      (z_h),
    .opcode (opcode_i),
    .mpc    (mpc)
  );

  usq_ctrl_store #(.AW(AW), .DW(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cs_we),
    .waddr (cs_waddr),
    .wdata (cs_wdata),
    .re    (~exec_q),
    .raddr (mpc),
    .rdata (mir)
  );

  assign mpc_o      = mpc;
  assign mir_o      = mir;
  assign mir_valid  = exec_q;
  assign alu_ctrl_o = mir[ALU_LSB +: ALU_W];
  assign c_wr_o     = mir[CW_LSB +: CW_W];
  assign mem_op_o   = mir[MEM_LSB +: MEM_W];
  assign b_src_o    = mir[BS_LSB +: BS_W];
endmodule

// File: rtl/usq_sequencer_chk.sv
module usq_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  opcode_i,
  input logic        alu_n,
  input logic        alu_z,
  input logic [8:0]  mpc_o,
  input logic [35:0] mir_o,
  input logic        mir_valid
);
  logic armed_q = 1'b0;
  always_ff @(posedge clk) armed_q <= 1'b1;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!armed_q)
    !rst_n |-> (mpc_o == 9'd0 && !mir_valid));

  // R3
  high_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mir_valid |=> (mpc_o[8] == ($past(mir_o[35]) | ($past(mir_o[24]) & $past(alu_z))
                                | ($past(mir_o[25]) & $past(alu_n)))));

  // R4
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mir_valid |=> (mpc_o[7:0] == ($past(mir_o[26]) ? (opcode_i | $past(mir_o[34:27]))
                                                   : $past(mir_o[34:27]))));

  // R8
  exec_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mir_valid |=> !mir_valid);

  // R8
  fetch_to_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mir_valid |=> mir_valid);

  // R8
  mir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mir_valid |=> $stable(mir_o));
endmodule

bind usq_sequencer usq_sequencer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .opcode_i  (opcode_i),
  .alu_n     (alu_n),
  .alu_z     (alu_z),
  .mpc_o     (mpc_o),
  .mir_o     (mir_o),
  .mir_valid (mir_valid)
);

// File: tb/test_usq_sequencer.sv
module test_usq_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_we = 1'b0;
  logic [8:0]  cs_waddr = '0;
  logic [35:0] cs_wdata = '0;
  logic [7:0]  opcode_i = '0;
  logic        alu_n = 1'b0, alu_z = 1'b0;
  logic [8:0]  mpc_o;
  logic [35:0] mir_o;
  logic        mir_valid;
  logic [7:0]  alu_ctrl_o;
  logic [8:0]  c_wr_o;
  logic [2:0]  mem_op_o;
  logic [3:0]  b_src_o;

  usq_sequencer i_usq_sequencer (
    .clk(clk), .rst_n(rst_n), .cs_we(cs_we), .cs_waddr(cs_waddr), .cs_wdata(cs_wdata),
    .opcode_i(opcode_i), .alu_n(alu_n), .alu_z(alu_z), .mpc_o(mpc_o), .mir_o(mir_o),
    .mir_valid(mir_valid), .alu_ctrl_o(alu_ctrl_o), .c_wr_o(c_wr_o),
    .mem_op_o(mem_op_o), .b_src_o(b_src_o)
  );

  always #4 clk = ~clk;

  int unsigned nchk = 0, nfail = 0;
  bit          done = 1'b0;
  bit          mon_on = 1'b0;
  logic [35:0] exp_cs [512];
  logic [8:0]  q_mpc [$];
  logic [35:0] q_word [$];
  logic [8:0]  last_mpc = '0;
  logic [3:0]  jam_seen [2][2];

  // model state: held fields and captured flags
  logic [8:0] m_ua;
  logic [2:0] m_sel;
  logic       m_n, m_z;

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [8:0] next_addr(input logic [8:0] ua, input logic [2:0] sel,
                                           input logic n, input logic z, input logic [7:0] op);
    logic [8:0] r;
    r[8]   = ua[8] | (sel[0] & z) | (sel[1] & n);
    r[7:0] = sel[2] ? (op | ua[7:0]) : ua[7:0];
    return r;
  endfunction

  function automatic logic [35:0] table_word(input int a);
    logic [31:0] h;
    logic [8:0]  ua;
    h  = a * 32'h9E3779B1;
    ua = 9'((a * 73 + 29) % 512);
    return {ua, 3'((a ^ (a >> 3)) & 7), h[23:0]};
  endfunction

  task automatic write_word(input int a, input logic [35:0] w);
    cs_we = 1'b1; cs_waddr = 9'(a); cs_wdata = w; exp_cs[a] = w;
    @(negedge clk);
    cs_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    // R1: reset state at the ports
    check(mpc_o == 9'd0, "R1 mpc in reset", 36'(mpc_o), 36'd0);
    check(mir_valid == 1'b0, "R1 valid in reset", 36'(mir_valid), 36'd0);
    @(negedge clk);
    m_ua = '0; m_sel = '0; m_n = 1'b0; m_z = 1'b0;
    rst_n = 1'b1;
  endtask

  // driver: starts at a fetch-cycle negedge, pushes expectations
  task automatic run_steps(input int steps, input bit rnd, input bit dn, input bit dz, input logic [7:0] dop);
    for (int i = 0; i < steps; i++) begin
      logic [8:0]  em;
      logic [35:0] w;
      logic        en, ez;
      opcode_i = rnd ? 8'($urandom) : dop;
      alu_n    = rnd ? 1'($urandom) : ~dn;   // ignored in fetch (R6)
      alu_z    = rnd ? 1'($urandom) : ~dz;
      em = next_addr(m_ua, m_sel, m_n, m_z, opcode_i);
      w  = exp_cs[em];
      q_mpc.push_back(em);
      q_word.push_back(w);
      @(negedge clk);
      en = rnd ? 1'($urandom) : dn;
      ez = rnd ? 1'($urandom) : dz;
      alu_n = en; alu_z = ez;
      opcode_i = 8'($urandom);
      jam_seen[en][ez][w[26:24] & 3'b011] = 1'b1;
      m_ua = w[35:27]; m_sel = w[26:24]; m_n = en; m_z = ez;
      @(negedge clk);
    end
  endtask

  // monitor: pops expectations as the design produces results
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (mon_on && rst_n) begin
        if (!mir_valid) begin
          if (q_mpc.size() > 0) begin
            last_mpc = mpc_o;
            // R3 R4 R9 next address
            check(mpc_o == q_mpc[0], "R3 R4 mpc", 36'(mpc_o), 36'(q_mpc[0]));
          end
        end else if (q_word.size() > 0) begin
          logic [35:0] w;
          w = q_word.pop_front();
          void'(q_mpc.pop_front());
          // R8 fetched word
          check(mir_o == w, "R8 mir", mir_o, w);
          // R2 field positions
          check({alu_ctrl_o, c_wr_o, mem_op_o, b_src_o} == w[23:0], "R2 fields",
                36'({alu_ctrl_o, c_wr_o, mem_op_o, b_src_o}), 36'(w[23:0]));
        end else begin
          check(1'b0, "R8 unexpected valid", 36'(mir_valid), 36'd0);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int a = 0; a < 512; a++) write_word(a, table_word(a));
    mon_on = 1'b1;

    // R5: zero-select branch taken (Z=1)
    rst_n = 1'b0;
    write_word(0, {9'h075, 3'b000, 24'h0A0B0C});
    write_word(9'h075, {9'h092, 3'b001, 24'h112233});
    do_reset();
    run_steps(3, 1'b0, 1'b1, 1'b1, 8'hFF);
    check(last_mpc == 9'h192, "R5 taken", 36'(last_mpc), 36'h192);

    // R5 and R6: Z=0 at capture, Z=1 in fetch cycles
    do_reset();
    run_steps(3, 1'b0, 1'b1, 1'b0, 8'hFF);
    check(last_mpc == 9'h092, "R6 R5 not taken", 36'(last_mpc), 36'h092);

    // R7: dispatch into the upper half
    rst_n = 1'b0;
    write_word(0, {9'h100, 3'b100, 24'h445566});
    do_reset();
    run_steps(2, 1'b0, 1'b0, 1'b0, 8'hC4);
    check(last_mpc == 9'h1C4, "R7 dispatch", 36'(last_mpc), 36'h1C4);

    // R9: opcode ignored without dispatch select
    rst_n = 1'b0;
    write_word(0, {9'h012, 3'b000, 24'h778899});
    do_reset();
    run_steps(2, 1'b0, 1'b1, 1'b1, 8'hFF);
    check(last_mpc == 9'h012, "R9 opcode ignored", 36'(last_mpc), 36'h012);

    // R1: first fetch reads address 0 despite inputs
    rst_n = 1'b0;
    write_word(0, table_word(0));
    do_reset();
    run_steps(1, 1'b0, 1'b1, 1'b1, 8'hFF);
    check(last_mpc == 9'h000, "R1 first fetch", 36'(last_mpc), 36'h000);

    // R3 R4 R8: long random chain over the table
    do_reset();
    run_steps(3000, 1'b1, 1'b0, 1'b0, 8'h00);
    for (int n = 0; n < 2; n++)
      for (int z = 0; z < 2; z++)
        check(jam_seen[n][z] == 4'hF, "R3 select coverage", 36'(jam_seen[n][z]), 36'hF);

    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule